// File: doc/BRIEF.md
# Data Pointer Address Generator

This block turns load, store and program-read requests into memory addresses. It works on three 16-bit data pointers, each made of a low byte and a high byte held in a register file outside the block. The register file presents all six bytes to the block every cycle. The block returns the effective address, plus a write-back that tells the register file which pointer to update and with what value. Four access modes are supported: plain indirect, post-increment, pre-decrement, and base plus an unsigned displacement.

The same datapath also adds or subtracts a small immediate to a whole pointer pair and reports zero, carry, negative, overflow and sign flags. A third kind of request places an 8-bit page byte above the last pointer to form a 24-bit program-memory address, with optional post-increment of that pointer. Results are registered and appear exactly one cycle after the request.

Top module: `ptr_agu`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all four strobes (`daddr_vld_o`, `paddr_vld_o`, `wb_vld_o`, `flg_vld_o`) are low and every data output is zero.
- R2: Op code 0 (access) with mode 0 (plain) returns the selected pointer `{hi,lo}` unchanged on `daddr_o` and raises no write-back.
- R3: Access with mode 1 (post-increment) returns the old pointer as the address and writes back old + 1 to the same pointer, modulo 2^16 (0xFFFF becomes 0x0000).
- R4: Access with mode 2 (pre-decrement) writes back old − 1, modulo 2^16, and uses that new value as the address.
- R5: Access with mode 3 (displacement) on pointer 1 or 2 returns pointer + q, where q is 6-bit unsigned (0..63) and the sum wraps modulo 2^16, and raises no write-back. On pointer 0 the request produces no strobe at all.
- R6: Op code 1 (word add) writes back pointer + K (K is 6-bit unsigned) to the selected pointer. It raises `flg_vld_o` with: Z = result is zero, C = carry out of bit 15, N = bit 15 of the result, V = signed overflow, S = N xor V.
- R7: Op code 2 (word subtract) writes back pointer − K with the same flags. C is the borrow out of bit 15 and V is signed overflow of the subtraction.
- R8: Op code 3 (program read) sets `paddr_o = {page_i, pointer 2}` and ignores `sel_i`. With mode 1 it also writes back pointer 2 + 1 (modulo 2^16) with `wb_sel_o = 2`. Any other mode gives no write-back. `daddr_vld_o` stays low.
- R9: A cycle without `req_i`, or a data request (op 0, 1 or 2) with `sel_i = 3`, produces no strobe.
- R10: Each strobe is a single-cycle pulse in the cycle after its request, and at most one of `daddr_vld_o`, `paddr_vld_o` and `flg_vld_o` is high at a time. `daddr_o` keeps its last value while no new data address is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe |
| op_i | input | 2 | 0 access, 1 word add, 2 word subtract, 3 program read |
| mode_i | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 displacement |
| sel_i | input | 2 | Pointer index 0..2 |
| disp_i | input | 6 | Displacement q |
| imm_i | input | 6 | Word immediate K |
| page_i | input | 8 | Program page byte |
| ptr_lo_i | input | 24 | Low bytes of the pointers, pointer n at bits 8n+7..8n |
| ptr_hi_i | input | 24 | High bytes of the pointers, same layout |
| daddr_vld_o | output | 1 | Data address strobe |
| daddr_o | output | 16 | Effective data address |
| paddr_vld_o | output | 1 | Program address strobe |
| paddr_o | output | 24 | Extended program address |
| wb_vld_o | output | 1 | Pointer write-back strobe |
| wb_sel_o | output | 2 | Pointer to update |
| wb_lo_o | output | 8 | New low byte |
| wb_hi_o | output | 8 | New high byte |
| flg_vld_o | output | 1 | Flag strobe |
| flg_z_o | output | 1 | Zero |
| flg_c_o | output | 1 | Carry or borrow |
| flg_n_o | output | 1 | Negative |
| flg_v_o | output | 1 | Overflow |
| flg_s_o | output | 1 | Sign |

## Verification
The bench drives the wrap points. Post-increment from 0xFFFF must give 0x0000, and pre-decrement from 0x0000 must give 0xFFFF. A design that used the wrong operand as the address in either mode would be one off in the address or in the write-back. The flag corners are also covered: adding across 0x7FFF, across the top of the range (0xFFC1 + 63), and subtracting to exactly zero or below it. A mix-up between carry and overflow, or between carry and borrow, shows up in those cases. Displacement on pointer 0 and pointer index 3 must stay silent, and the program-read wrap must leave the page byte untouched; a design that let a stray strobe or write-back through would corrupt a pointer.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;
  typedef enum logic [1:0] {
    OP_ACCESS = 2'd0,
    OP_WADD   = 2'd1,
    OP_WSUB   = 2'd2,
    OP_XPROG  = 2'd3
  } agu_op_e;

  typedef enum logic [1:0] {
    AM_PLAIN   = 2'd0,
    AM_POSTINC = 2'd1,
    AM_PREDEC  = 2'd2,
    AM_DISP    = 2'd3
  } agu_mode_e;

  typedef struct packed {
    logic z;
    logic c;
    logic n;
    logic v;
    logic s;
  } agu_flags_t;
endpackage

// File: rtl/ptr_agu_pick.sv
module ptr_agu_pick #(
  parameter int NPTR = 3,
  parameter int DW   = 8,
  parameter int SELW = 2,
  localparam int AW  = 2 * DW
) (
  input  logic [NPTR*DW-1:0] lo_i,
  input  logic [NPTR*DW-1:0] hi_i,
  input  logic [SELW-1:0]    sel_i,
  output logic [AW-1:0]      pair_o,
  output logic [AW-1:0]      last_o,
  output logic               sel_ok_o
);
  logic [AW-1:0] pairs [NPTR];

  for (genvar g = 0; g < NPTR; g++) begin : g_pair
    assign pairs[g] = {hi_i[g*DW +: DW], lo_i[g*DW +: DW]};
  end

  assign last_o   = pairs[NPTR-1];
  assign sel_ok_o = int'(sel_i) < NPTR;

  always_comb begin
    pair_o = '0;
    for (int i = 0; i < NPTR; i++) begin
      if (int'(sel_i) == i) pair_o = pairs[i];
    end
  end
endmodule

// File: rtl/ptr_agu_ea.sv
module ptr_agu_ea import ptr_agu_pkg::*; #(
  parameter int AW = 16,
  parameter int QW = 6
) (
  input  logic [AW-1:0] ptr_i,
  input  agu_mode_e     mode_i,
  input  logic [QW-1:0] disp_i,
  output logic [AW-1:0] ea_o,
  output logic [AW-1:0] upd_o,
  output logic          upd_en_o
);
  logic [AW-1:0] inc, dec, dsum;

  assign inc  = ptr_i + AW'(1);
  assign dec  = ptr_i - AW'(1);
  assign dsum = ptr_i + {{(AW-QW){1'b0}}, disp_i};

  always_comb begin
    ea_o     = ptr_i;
    upd_o    = ptr_i;
    upd_en_o = 1'b0;
    unique case (mode_i)
      AM_POSTINC: begin
        upd_o    = inc;
        upd_en_o = 1'b1;
      end
      AM_PREDEC: begin
        ea_o     = dec;
        upd_o    = dec;
        upd_en_o = 1'b1;
      end
      AM_DISP:  ea_o = dsum;
      default:  ea_o = ptr_i;
    endcase
  end
endmodule

// File: rtl/ptr_agu_walu.sv
module ptr_agu_walu import ptr_agu_pkg::*; #(
  parameter int AW = 16,
  parameter int KW = 6
) (
  input  logic [AW-1:0] pair_i,
  input  logic [KW-1:0] imm_i,
  input  logic          sub_i,
  output logic [AW-1:0] res_o,
  output agu_flags_t    flags_o
);
  logic [AW:0] wide, opnd;

  assign opnd  = {{(AW+1-KW){1'b0}}, imm_i};
  assign wide  = sub_i ? ({1'b0, pair_i} - opnd) : ({1'b0, pair_i} + opnd);
  assign res_o = wide[AW-1:0];

  always_comb begin
    flags_o.z = ~|res_o;
    flags_o.c = wide[AW];
    flags_o.n = res_o[AW-1];
    flags_o.v = sub_i ? (pair_i[AW-1] & ~res_o[AW-1])
                      : (~pair_i[AW-1] & res_o[AW-1]);
    flags_o.s = flags_o.n ^ flags_o.v;
  end
endmodule

// File: rtl/ptr_agu.sv
module ptr_agu import ptr_agu_pkg::*; #(
  parameter int NPTR = 3,
  parameter int DW   = 8,
  parameter int QW   = 6,
  parameter int KW   = 6,
  parameter int PGW  = 8,
  localparam int AW  = 2 * DW,
  localparam int SELW = $clog2(NPTR + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [1:0]        op_i,
  input  logic [1:0]        mode_i,
  input  logic [SELW-1:0]   sel_i,
  input  logic [QW-1:0]     disp_i,
  input  logic [KW-1:0]     imm_i,
  input  logic [PGW-1:0]    page_i,
  input  logic [NPTR*DW-1:0] ptr_lo_i,
  input  logic [NPTR*DW-1:0] ptr_hi_i,
  output logic              daddr_vld_o,
  output logic [AW-1:0]     daddr_o,
  output logic              paddr_vld_o,
  output logic [PGW+AW-1:0] paddr_o,
  output logic              wb_vld_o,
  output logic [SELW-1:0]   wb_sel_o,
  output logic [DW-1:0]     wb_lo_o,
  output logic [DW-1:0]     wb_hi_o,
  output logic              flg_vld_o,
  output logic              flg_z_o,
  output logic              flg_c_o,
  output logic              flg_n_o,
  output logic              flg_v_o,
  output logic              flg_s_o
);
  agu_op_e       op;
  agu_mode_e     mode, ea_mode;
  logic [AW-1:0] pick_ptr, last_ptr, ea_ptr, ea, upd, wres;
  logic          sel_ok, upd_en;
  agu_flags_t    wflags;

  assign op   = agu_op_e'(op_i);
  assign mode = agu_mode_e'(mode_i);

  ptr_agu_pick #(.NPTR(NPTR), .DW(DW), .SELW(SELW)) u_pick (
    .lo_i(ptr_lo_i), .hi_i(ptr_hi_i), .sel_i(sel_i),
    .pair_o(pick_ptr), .last_o(last_ptr), .sel_ok_o(sel_ok)
  );

  // program reads always use the last pointer and only plain/post-increment
  logic is_xp;
  assign is_xp   = (op == OP_XPROG);
  assign ea_ptr  = is_xp ? last_ptr : pick_ptr;
  assign ea_mode = is_xp ? ((mode == AM_POSTINC) ? AM_POSTINC : AM_PLAIN) : mode;

  ptr_agu_ea #(.AW(AW), .QW(QW)) u_ea (
    .ptr_i(ea_ptr), .mode_i(ea_mode), .disp_i(disp_i),
    .ea_o(ea), .upd_o(upd), .upd_en_o(upd_en)
  );

  ptr_agu_walu #(.AW(AW), .KW(KW)) u_walu (
    .pair_i(pick_ptr), .imm_i(imm_i), .sub_i(op == OP_WSUB),
    .res_o(wres), .flags_o(wflags)
  );

  // next-state
  logic              acc_go, word_go, xp_go;
  logic              wb_go;
  logic [SELW-1:0]   wb_sel_d;
  logic [AW-1:0]     wb_val_d;
  logic [PGW+AW-1:0] paddr_d;

  always_comb begin
    acc_go  = req_i && (op == OP_ACCESS) && sel_ok &&
              !((mode == AM_DISP) && (sel_i == '0));
    word_go = req_i && ((op == OP_WADD) || (op == OP_WSUB)) && sel_ok;
    xp_go   = req_i && is_xp;
    paddr_d = {page_i, ea};
    wb_go    = 1'b0;
    wb_sel_d = sel_i;
    wb_val_d = upd;
    if (word_go) begin
      wb_go    = 1'b1;
      wb_val_d = wres;
    end else if (acc_go) begin
      wb_go = upd_en;
    end else if (xp_go) begin
      wb_go    = upd_en;
      wb_sel_d = SELW'(NPTR - 1);
    end
  end

  // registers
  logic [AW-1:0]     daddr_q;
  logic [PGW+AW-1:0] paddr_q;
  logic [SELW-1:0]   wb_sel_q;
  logic [AW-1:0]     wb_val_q;
  agu_flags_t        flags_q;
  logic              dv_q, pv_q, wv_q, fv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q     <= 1'b0;
      pv_q     <= 1'b0;
      wv_q     <= 1'b0;
      fv_q     <= 1'b0;
      daddr_q  <= '0;
      paddr_q  <= '0;
      wb_sel_q <= '0;
      wb_val_q <= '0;
      flags_q  <= '0;
    end else begin
      dv_q <= acc_go;
      pv_q <= xp_go;
      wv_q <= wb_go;
      fv_q <= word_go;
      if (acc_go)  daddr_q <= ea;
      if (xp_go)   paddr_q <= paddr_d;
      if (wb_go) begin
        wb_sel_q <= wb_sel_d;
        wb_val_q <= wb_val_d;
      end
      if (word_go) flags_q <= wflags;
    end
  end

  assign daddr_vld_o = dv_q;
  assign daddr_o     = daddr_q;
  assign paddr_vld_o = pv_q;
  assign paddr_o     = paddr_q;
  assign wb_vld_o    = wv_q;
  assign wb_sel_o    = wb_sel_q;
  assign wb_lo_o     = wb_val_q[DW-1:0];
  assign wb_hi_o     = wb_val_q[AW-1:DW];
  assign flg_vld_o   = fv_q;
  assign flg_z_o     = flags_q.z;
  assign flg_c_o     = flags_q.c;
  assign flg_n_o     = flags_q.n;
  assign flg_v_o     = flags_q.v;
  assign flg_s_o     = flags_q.s;
endmodule

// File: rtl/ptr_agu_chk.sv
module ptr_agu_chk #(
  parameter int NPTR = 3,
  parameter int DW   = 8,
  parameter int PGW  = 8,
  localparam int AW  = 2 * DW,
  localparam int SELW = $clog2(NPTR + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_i,
  input logic [1:0]        op_i,
  input logic [1:0]        mode_i,
  input logic [SELW-1:0]   sel_i,
  input logic [PGW-1:0]    page_i,
  input logic              daddr_vld_o,
  input logic [AW-1:0]     daddr_o,
  input logic              paddr_vld_o,
  input logic [PGW+AW-1:0] paddr_o,
  input logic              wb_vld_o,
  input logic [SELW-1:0]   wb_sel_o,
  input logic [DW-1:0]     wb_lo_o,
  input logic [DW-1:0]     wb_hi_o,
  input logic              flg_vld_o,
  input logic              flg_z_o
);
  logic          armed;
  logic [AW-1:0] wb;
  assign wb = {wb_hi_o, wb_lo_o};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(req_i) |-> !(daddr_vld_o || paddr_vld_o || wb_vld_o || flg_vld_o));

  // R3
  postinc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(req_i && op_i == 2'd0 && mode_i == 2'd1 && int'(sel_i) < NPTR)
    |-> wb_vld_o && daddr_vld_o && wb == daddr_o + AW'(1));

  // R4
  predec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(req_i && op_i == 2'd0 && mode_i == 2'd2 && int'(sel_i) < NPTR)
    |-> wb_vld_o && daddr_vld_o && wb == daddr_o);

  // R5
  disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(req_i && op_i == 2'd0 && mode_i == 2'd3) |-> !wb_vld_o);

  // R6
  flag_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flg_vld_o |-> wb_vld_o && (flg_z_o == (wb == '0)));

  // R8
  xprog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(req_i && op_i == 2'd3)
    |-> paddr_vld_o && !daddr_vld_o && paddr_o[PGW+AW-1:AW] == $past(page_i));

  // R8
  xprog_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(req_i && op_i == 2'd3 && mode_i == 2'd1)
    |-> wb_vld_o && int'(wb_sel_o) == NPTR - 1 && wb == paddr_o[AW-1:0] + AW'(1));

  // R10
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({daddr_vld_o, paddr_vld_o, flg_vld_o}));
endmodule

bind ptr_agu ptr_agu_chk #(.NPTR(NPTR), .DW(DW), .PGW(PGW)) u_chk (.*);

// File: tb/tb_ptr_agu.sv
module tb_ptr_agu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i;
  logic [1:0]  op_i, mode_i, sel_i;
  logic [5:0]  disp_i, imm_i;
  logic [7:0]  page_i;
  logic [23:0] ptr_lo_i, ptr_hi_i;
  logic        daddr_vld_o, paddr_vld_o, wb_vld_o, flg_vld_o;
  logic [15:0] daddr_o;
  logic [23:0] paddr_o;
  logic [1:0]  wb_sel_o;
  logic [7:0]  wb_lo_o, wb_hi_o;
  logic        flg_z_o, flg_c_o, flg_n_o, flg_v_o, flg_s_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ptr_agu dut (.*);

  typedef struct packed {
    logic        dv;
    logic [15:0] da;
    logic        pv;
    logic [23:0] pa;
    logic        wv;
    logic [1:0]  ws;
    logic [15:0] wd;
    logic        fv;
    logic [4:0]  fl; // z c n v s
  } exp_t;

  function automatic exp_t model(input logic [1:0] op, input logic [1:0] md,
      input logic [1:0] sel, input logic [5:0] q, input logic [5:0] k,
      input logic [7:0] pg, input logic [15:0] p0, input logic [15:0] p1,
      input logic [15:0] p2);
    exp_t e = '0;
    logic [15:0] p;
    int u, sg;
    logic z, c, n, v;
    p = (sel == 2'd0) ? p0 : (sel == 2'd1) ? p1 : p2;
    if (op == 2'd0 && sel != 2'd3) begin
      case (md)
        2'd0: begin e.dv = 1; e.da = p; end
        2'd1: begin e.dv = 1; e.da = p; e.wv = 1; e.ws = sel; e.wd = p + 16'd1; end
        2'd2: begin e.dv = 1; e.da = p - 16'd1; e.wv = 1; e.ws = sel; e.wd = p - 16'd1; end
        default: if (sel != 2'd0) begin e.dv = 1; e.da = p + {10'd0, q}; end
      endcase
    end else if ((op == 2'd1 || op == 2'd2) && sel != 2'd3) begin
      u  = (op == 2'd1) ? int'(p) + int'(k) : int'(p) - int'(k);
      sg = (op == 2'd1) ? int'($signed(p)) + int'(k) : int'($signed(p)) - int'(k);
      e.wv = 1; e.ws = sel; e.wd = u[15:0]; e.fv = 1;
      z = (u[15:0] == 16'd0);
      c = (u > 65535) || (u < 0);
      n = u[15];
      v = (sg > 32767) || (sg < -32768);
      e.fl = {z, c, n, v, n ^ v};
    end else if (op == 2'd3) begin
      e.pv = 1; e.pa = {pg, p2};
      if (md == 2'd1) begin e.wv = 1; e.ws = 2'd2; e.wd = p2 + 16'd1; end
    end
    return e;
  endfunction

  function automatic exp_t observed(input exp_t mask);
    exp_t g = '0;
    g.dv = daddr_vld_o; g.pv = paddr_vld_o; g.wv = wb_vld_o; g.fv = flg_vld_o;
    if (mask.dv) g.da = daddr_o;
    if (mask.pv) g.pa = paddr_o;
    if (mask.wv) begin g.ws = wb_sel_o; g.wd = {wb_hi_o, wb_lo_o}; end
    if (mask.fv) g.fl = {flg_z_o, flg_c_o, flg_n_o, flg_v_o, flg_s_o};
    return g;
  endfunction

  task automatic check(input string tag, input exp_t got, input exp_t exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic run(input string tag, input logic [1:0] op, input logic [1:0] md,
      input logic [1:0] sel, input logic [5:0] q, input logic [5:0] k,
      input logic [7:0] pg, input logic [15:0] p0, input logic [15:0] p1,
      input logic [15:0] p2);
    exp_t e;
    @(negedge clk);
    req_i = 1'b1; op_i = op; mode_i = md; sel_i = sel; disp_i = q; imm_i = k; page_i = pg;
    ptr_lo_i = {p2[7:0], p1[7:0], p0[7:0]};
    ptr_hi_i = {p2[15:8], p1[15:8], p0[15:8]};
    e = model(op, md, sel, q, k, pg, p0, p1, p2);
    @(negedge clk);
    req_i = 1'b0;
    check(tag, observed(e), e);
  endtask

  // R9 R10: cycle after a request with no new request is silent, data address held
  task automatic idle_check(input string tag);
    logic [15:0] held;
    exp_t z = '0;
    held = daddr_o;
    @(negedge clk);
    check(tag, observed(z), z);
    checks++;
    if (daddr_o !== held) begin
      fails++;
      $display("FAIL %s daddr held got=%h exp=%h", tag, daddr_o, held);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd20250917);
    rst_n = 1'b0; req_i = 1'b0; op_i = '0; mode_i = '0; sel_i = '0;
    disp_i = '0; imm_i = '0; page_i = '0; ptr_lo_i = '0; ptr_hi_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if ({daddr_vld_o, paddr_vld_o, wb_vld_o, flg_vld_o, daddr_o, paddr_o, wb_lo_o, wb_hi_o,
         flg_z_o, flg_c_o, flg_n_o, flg_v_o, flg_s_o} !== '0) begin
      fails++;
      $display("FAIL R1 outputs in reset got=nonzero exp=0");
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if ({daddr_vld_o, paddr_vld_o, wb_vld_o, flg_vld_o, daddr_o} !== '0) begin
      fails++;
      $display("FAIL R1 after release got=nonzero exp=0");
    end

    // directed corners
    run("R2 plain",            2'd0, 2'd0, 2'd1, 6'd5,  6'd0,  8'h00, 16'h1111, 16'hA55A, 16'h3333);
    idle_check("R10 pulse/hold");
    run("R3 postinc wrap",     2'd0, 2'd1, 2'd0, 6'd0,  6'd0,  8'h00, 16'hFFFF, 16'h0001, 16'h0002);
    run("R3 postinc",          2'd0, 2'd1, 2'd2, 6'd0,  6'd0,  8'h00, 16'h0000, 16'h0001, 16'h12FF);
    run("R4 predec wrap",      2'd0, 2'd2, 2'd1, 6'd0,  6'd0,  8'h00, 16'h4444, 16'h0000, 16'h0002);
    run("R4 predec",           2'd0, 2'd2, 2'd2, 6'd0,  6'd0,  8'h00, 16'h4444, 16'h0000, 16'h1300);
    run("R5 disp wrap",        2'd0, 2'd3, 2'd2, 6'd63, 6'd0,  8'h00, 16'h0000, 16'h0000, 16'hFFF0);
    run("R5 disp max",         2'd0, 2'd3, 2'd1, 6'd63, 6'd0,  8'h00, 16'h0000, 16'h00C1, 16'h0000);
    run("R5 disp ptr0 silent", 2'd0, 2'd3, 2'd0, 6'd9,  6'd0,  8'h00, 16'h2222, 16'h0000, 16'h0000);
    run("R6 add carry",        2'd1, 2'd0, 2'd0, 6'd0,  6'd63, 8'h00, 16'hFFC5, 16'h0000, 16'h0000);
    run("R6 add overflow",     2'd1, 2'd0, 2'd1, 6'd0,  6'd1,  8'h00, 16'h0000, 16'h7FFF, 16'h0000);
    run("R6 add to zero",      2'd1, 2'd0, 2'd2, 6'd0,  6'd63, 8'h00, 16'h0000, 16'h0000, 16'hFFC1);
    run("R7 sub borrow",       2'd2, 2'd0, 2'd0, 6'd0,  6'd1,  8'h00, 16'h0000, 16'h0000, 16'h0000);
    run("R7 sub overflow",     2'd2, 2'd0, 2'd1, 6'd0,  6'd1,  8'h00, 16'h0000, 16'h8000, 16'h0000);
    run("R7 sub to zero",      2'd2, 2'd0, 2'd2, 6'd0,  6'd5,  8'h00, 16'h0000, 16'h0000, 16'h0005);
    run("R8 prog plain",       2'd3, 2'd0, 2'd0, 6'd0,  6'd0,  8'h5A, 16'h1234, 16'h5678, 16'h9ABC);
    run("R8 prog postinc wrap",2'd3, 2'd1, 2'd1, 6'd0,  6'd0,  8'hC3, 16'h1234, 16'h5678, 16'hFFFF);
    run("R8 prog predec plain",2'd3, 2'd2, 2'd3, 6'd0,  6'd0,  8'h01, 16'h1234, 16'h5678, 16'h0000);
    run("R9 sel3 access",      2'd0, 2'd1, 2'd3, 6'd0,  6'd0,  8'h00, 16'h1234, 16'h5678, 16'h9ABC);
    run("R9 sel3 word",        2'd1, 2'd0, 2'd3, 6'd0,  6'd7,  8'h00, 16'h1234, 16'h5678, 16'h9ABC);
    idle_check("R9 no request");

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] op, md, sl;
      logic [15:0] a, b, c;
      op = 2'($urandom_range(0, 3));
      md = 2'($urandom_range(0, 3));
      sl = ($urandom_range(0, 15) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
      a = ($urandom_range(0, 7) == 0) ? 16'hFFFF : 16'($urandom);
      b = ($urandom_range(0, 7) == 0) ? 16'h8000 : 16'($urandom);
      c = ($urandom_range(0, 7) == 0) ? 16'h0000 : 16'($urandom);
      run("R2-R9 random", op, md, sl, 6'($urandom), 6'($urandom), 8'($urandom), a, b, c);
      if ($urandom_range(0, 9) == 0) idle_check("R10 random idle");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule